// File: doc/BRIEF.md
# TDM Serial Stream to DS1 Channel Mapper

This block sits between a 2.048 Mbit/s time-division serial bus and a 24-channel DS1 trunk section. Each serial frame lasts 125 µs and holds 32 eight-bit channels. A frame pulse marks the start of each frame. The block turns three incoming streams into parallel words: one data stream and two control streams. Data channels go to the DS1 timeslot buffer as writes. The first control stream yields per-channel control words and two master control words. The second control stream yields per-channel signalling bits.

In the other direction, the block asks the DS1-side buffer for received data and per-channel status, one byte at a time, ahead of each channel. It then serialises two outgoing streams. The data stream carries the 24 DS1 channels and fills its unused slots with an idle byte. The status stream carries per-channel status, a phase status word and two master status words. One master-word bit drives an external control pin. An external status pin is reported back in the second master status word.

Data and control streams skip different channel positions. On the data streams, every fourth channel starting at 0 is unused. On the control streams, every fourth channel starting at 3 is either unused or holds a master or phase word.

Top module: `tdm_ds1_mapper`

## Requirements
- R1: A frame is 256 bit periods, channel c covering periods 8c..8c+7. A frame pulse sampled high on a falling clock edge marks period 0 (bit 0 of channel 0). Without a pulse the count wraps from 255 to 0 by itself.
- R2: A data-input channel c with c mod 4 not 0 produces one write (txWrEn high for one period) in the period after its last bit. The write carries slot c - c/4 (1..24) and the byte received MSB first. Channels with c mod 4 = 0 produce no write.
- R3: A control channel c with c mod 4 not 3 produces one per-channel write in the period after its last bit. The write carries slot c - c/4 + 1 (1..24), the control-stream-0 byte and the control-stream-1 byte of that channel.
- R4: Control-stream-0 channel 15 loads masterCtl1 and channel 31 loads masterCtl2, in the period after the channel ends. Neither produces a per-channel write.
- R5: extCtl takes bit 3 of masterCtl1. It changes only at the end of bit period 255.
- R6: Output data channel c with c mod 4 not 0 carries the byte read back for slot c - c/4. Channels with c mod 4 = 0 carry 8'hFF. Bits go out MSB first and change on the rising clock edge.
- R7: A read request for output channel c is a one-period pulse on dataRdEn or statRdEn in period 8c-2 (mod 256). The returned byte is expected on the next period.
- R8: Status channel 3 carries phaseStat and channel 15 carries masterStat1. Channel 31 carries masterStat2 with bit 5 replaced by extStatusIn as sampled in period 255 of the previous frame. Channels with c mod 4 not 3 carry per-channel status for slot c - c/4 + 1. The other channels (7, 11, 19, 23, 27) carry 8'hFF.
- R9: A frame pulse in a period whose count is not 0 makes that period bit 0 of channel 0. The interrupted channel produces no write.
- R10: During reset all write and read strobes are low, the master words and extCtl are 0, and both serial outputs are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 2.048 MHz bit clock |
| rstN | input | 1 | asynchronous active-low reset |
| framePulse | input | 1 | marks bit 0 of channel 0 |
| dataIn | input | 1 | serial data to transmit |
| ctl0In | input | 1 | serial control stream 0 |
| ctl1In | input | 1 | serial signalling stream |
| extStatusIn | input | 1 | external status pin |
| txWrEn | output | 1 | DS1 transmit-buffer write strobe |
| txWrSlot | output | 5 | DS1 slot 1..24 of the write |
| txWrData | output | 8 | byte written |
| pcwWrEn | output | 1 | per-channel control write strobe |
| pcwSlot | output | 5 | DS1 slot of the control write |
| pcwCtl | output | 8 | per-channel control byte |
| pcwSig | output | 8 | per-channel signalling byte |
| masterCtl1 | output | 8 | master control word 1 |
| masterCtl2 | output | 8 | master control word 2 |
| extCtl | output | 1 | external control pin |
| dataRdEn | output | 1 | receive-buffer read request |
| dataRdSlot | output | 5 | slot requested |
| dataRdData | input | 8 | byte returned one period later |
| statRdEn | output | 1 | per-channel status read request |
| statRdSlot | output | 5 | slot requested |
| statRdData | input | 8 | status byte returned one period later |
| phaseStat | input | 8 | phase status word |
| masterStat1 | input | 8 | master status word 1 |
| masterStat2 | input | 8 | master status word 2 (bit 5 replaced) |
| dataOut | output | 1 | serial received data |
| statusOut | output | 1 | serial status stream |

## Verification
The hardest case is a frame pulse that arrives exactly where the old count would have closed a channel. If the block trusted its stale count there, it would write a control word for a channel that was never received. The bench moves its own frame start so that the pulse lands on old count 103 and checks that no write appears. Two whole frames without any pulse show that the count wraps by itself. The external status bit is toggled mid-frame, so that only the value present in period 255 may appear in the next frame's master status word.

// File: rtl/tdm_map_pkg.sv
package tdm_map_pkg;
  localparam int BYTE_W   = 8;
  localparam int NUM_CH   = 32;
  localparam int GROUP    = 4;
  localparam int CH_W     = $clog2(NUM_CH);
  localparam int BIT_W    = $clog2(BYTE_W);
  localparam int CNT_W    = CH_W + BIT_W;
  localparam int GRP_SH   = $clog2(GROUP);
  localparam int DS1_CH   = NUM_CH - NUM_CH / GROUP;
  localparam int SLOT_W   = $clog2(DS1_CH + 1);
  localparam int PSW_CH   = 3;
  localparam int MCW1_CH  = 15;
  localparam int MCW2_CH  = 31;
  localparam int EXT_CTL_BIT  = 3;
  localparam int EXT_STAT_BIT = 5;
  localparam logic [BYTE_W-1:0] IDLE_BYTE = '1;

  typedef logic [CH_W-1:0]   ch_t;
  typedef logic [SLOT_W-1:0] slot_t;
  typedef logic [BYTE_W-1:0] byte_t;

  // strobes handed from frame control to datapath for the coming edge
  typedef struct packed {
    logic byteDone;
    ch_t  doneCh;
    logic loadOut;
    ch_t  loadCh;
    logic reqOut;
    ch_t  reqCh;
    logic frameEnd;
  } strobe_t;

  function automatic logic isDataCh(ch_t ch);
    return ch[GRP_SH-1:0] != '0;
  endfunction

  function automatic logic isCtlCh(ch_t ch);
    return ch[GRP_SH-1:0] != '1;
  endfunction

  function automatic slot_t dataSlot(ch_t ch);
    return slot_t'(ch) - slot_t'(ch >> GRP_SH);
  endfunction

  function automatic slot_t ctlSlot(ch_t ch);
    return dataSlot(ch) + slot_t'(1);
  endfunction
endpackage

// File: rtl/tdm_frame_ctl.sv
module tdm_frame_ctl
  import tdm_map_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    framePulse,
  output strobe_t stb
);
  localparam logic [BIT_W-1:0] REQ_BIT = BIT_W'(BYTE_W - 3);

  logic             fpS;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] idxEnd;
  ch_t              curCh;
  logic [BIT_W-1:0] curBit;

  // frame pulse sampled mid-period, like every serial input
  always_ff @(negedge clk or negedge rstN) begin
    if (!rstN) fpS <= 1'b0;
    else       fpS <= framePulse;
  end

  // a pulse forces the ending period to index 0 (R1, R9)
  assign idxEnd = fpS ? '0 : cnt;
  assign curCh  = idxEnd[CNT_W-1:BIT_W];
  assign curBit = idxEnd[BIT_W-1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cnt <= '0;
    else       cnt <= idxEnd + 1'b1;
  end

  always_comb begin
    stb.byteDone = (curBit == '1);
    stb.doneCh   = curCh;
    stb.loadOut  = (curBit == '1);
    stb.loadCh   = curCh + 1'b1;
    stb.reqOut   = (curBit == REQ_BIT);
    stb.reqCh    = curCh + 1'b1;
    stb.frameEnd = (idxEnd == '1);
  end
endmodule

// File: rtl/tdm_chan_path.sv
module tdm_chan_path
  import tdm_map_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  strobe_t stb,
  input  logic    dataIn,
  input  logic    ctl0In,
  input  logic    ctl1In,
  input  logic    extStatusIn,
  input  byte_t   dataRdData,
  input  byte_t   statRdData,
  input  byte_t   phaseStat,
  input  byte_t   masterStat1,
  input  byte_t   masterStat2,
  output logic    txWrEn,
  output slot_t   txWrSlot,
  output byte_t   txWrData,
  output logic    pcwWrEn,
  output slot_t   pcwSlot,
  output byte_t   pcwCtl,
  output byte_t   pcwSig,
  output byte_t   masterCtl1,
  output byte_t   masterCtl2,
  output logic    extCtl,
  output logic    dataRdEn,
  output slot_t   dataRdSlot,
  output logic    statRdEn,
  output slot_t   statRdSlot,
  output logic    dataOut,
  output logic    statusOut
);
  localparam int IN_LANES  = 3;
  localparam int OUT_LANES = 2;

  logic  laneIn   [IN_LANES];
  logic  laneS    [IN_LANES];
  byte_t laneSr   [IN_LANES];
  byte_t laneByte [IN_LANES];
  logic  extS;
  logic  extLatch;
  byte_t outLoad  [OUT_LANES];
  byte_t outSr    [OUT_LANES];

  assign laneIn[0] = dataIn;
  assign laneIn[1] = ctl0In;
  assign laneIn[2] = ctl1In;

  // input deserialisers, MSB first, sampled on the falling edge
  for (genvar g = 0; g < IN_LANES; g++) begin : g_inLane
    always_ff @(negedge clk or negedge rstN) begin
      if (!rstN) laneS[g] <= 1'b0;
      else       laneS[g] <= laneIn[g];
    end
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) laneSr[g] <= '0;
      else       laneSr[g] <= laneByte[g];
    end
    assign laneByte[g] = {laneSr[g][BYTE_W-2:0], laneS[g]};
  end

  always_ff @(negedge clk or negedge rstN) begin
    if (!rstN) extS <= 1'b0;
    else       extS <= extStatusIn;
  end

  // channel writes toward the DS1 side (R2, R3)
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txWrEn   <= 1'b0;
      txWrSlot <= '0;
      txWrData <= '0;
      pcwWrEn  <= 1'b0;
      pcwSlot  <= '0;
      pcwCtl   <= '0;
      pcwSig   <= '0;
    end else begin
      txWrEn  <= stb.byteDone && isDataCh(stb.doneCh);
      pcwWrEn <= stb.byteDone && isCtlCh(stb.doneCh);
      if (stb.byteDone) begin
        txWrSlot <= dataSlot(stb.doneCh);
        txWrData <= laneByte[0];
        pcwSlot  <= ctlSlot(stb.doneCh);
        pcwCtl   <= laneByte[1];
        pcwSig   <= laneByte[2];
      end
    end
  end

  // master words and once-per-frame pins (R4, R5, R8)
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      masterCtl1 <= '0;
      masterCtl2 <= '0;
      extCtl     <= 1'b0;
      extLatch   <= 1'b0;
    end else begin
      if (stb.byteDone && stb.doneCh == ch_t'(MCW1_CH)) masterCtl1 <= laneByte[1];
      if (stb.byteDone && stb.doneCh == ch_t'(MCW2_CH)) masterCtl2 <= laneByte[1];
      if (stb.frameEnd) begin
        extCtl   <= masterCtl1[EXT_CTL_BIT];
        extLatch <= extS;
      end
    end
  end

  // read requests two periods ahead of each output channel (R7)
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataRdEn   <= 1'b0;
      dataRdSlot <= '0;
      statRdEn   <= 1'b0;
      statRdSlot <= '0;
    end else begin
      dataRdEn <= stb.reqOut && isDataCh(stb.reqCh);
      statRdEn <= stb.reqOut && isCtlCh(stb.reqCh);
      if (stb.reqOut) begin
        dataRdSlot <= dataSlot(stb.reqCh);
        statRdSlot <= ctlSlot(stb.reqCh);
      end
    end
  end

  // byte chosen for each output lane at the channel boundary (R6, R8)
  always_comb begin
    outLoad[0] = isDataCh(stb.loadCh) ? dataRdData : IDLE_BYTE;
    if (stb.loadCh == ch_t'(PSW_CH)) begin
      outLoad[1] = phaseStat;
    end else if (stb.loadCh == ch_t'(MCW1_CH)) begin
      outLoad[1] = masterStat1;
    end else if (stb.loadCh == ch_t'(MCW2_CH)) begin
      outLoad[1] = masterStat2;
      outLoad[1][EXT_STAT_BIT] = extLatch;
    end else if (isCtlCh(stb.loadCh)) begin
      outLoad[1] = statRdData;
    end else begin
      outLoad[1] = IDLE_BYTE;
    end
  end

  for (genvar g = 0; g < OUT_LANES; g++) begin : g_outLane
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)            outSr[g] <= IDLE_BYTE;
      else if (stb.loadOut) outSr[g] <= outLoad[g];
      else                  outSr[g] <= {outSr[g][BYTE_W-2:0], 1'b1};
    end
  end

  assign dataOut   = outSr[0][BYTE_W-1];
  assign statusOut = outSr[1][BYTE_W-1];
endmodule

// File: rtl/tdm_ds1_mapper.sv
module tdm_ds1_mapper
  import tdm_map_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              framePulse,
  input  logic              dataIn,
  input  logic              ctl0In,
  input  logic              ctl1In,
  input  logic              extStatusIn,
  output logic              txWrEn,
  output logic [SLOT_W-1:0] txWrSlot,
  output logic [BYTE_W-1:0] txWrData,
  output logic              pcwWrEn,
  output logic [SLOT_W-1:0] pcwSlot,
  output logic [BYTE_W-1:0] pcwCtl,
  output logic [BYTE_W-1:0] pcwSig,
  output logic [BYTE_W-1:0] masterCtl1,
  output logic [BYTE_W-1:0] masterCtl2,
  output logic              extCtl,
  output logic              dataRdEn,
  output logic [SLOT_W-1:0] dataRdSlot,
  input  logic [BYTE_W-1:0] dataRdData,
  output logic              statRdEn,
  output logic [SLOT_W-1:0] statRdSlot,
  input  logic [BYTE_W-1:0] statRdData,
  input  logic [BYTE_W-1:0] phaseStat,
  input  logic [BYTE_W-1:0] masterStat1,
  input  logic [BYTE_W-1:0] masterStat2,
  output logic              dataOut,
  output logic              statusOut
);
  strobe_t stb;

  tdm_frame_ctl u_ctl (
    .clk        (clk),
    .rstN       (rstN),
    .framePulse (framePulse),
    .stb        (stb)
  );

  tdm_chan_path u_path (
    .clk         (clk),
    .rstN        (rstN),
    .stb         (stb),
    .dataIn      (dataIn),
    .ctl0In      (ctl0In),
    .ctl1In      (ctl1In),
    .extStatusIn (extStatusIn),
    .dataRdData  (dataRdData),
    .statRdData  (statRdData),
    .phaseStat   (phaseStat),
    .masterStat1 (masterStat1),
    .masterStat2 (masterStat2),
    .txWrEn      (txWrEn),
    .txWrSlot    (txWrSlot),
    .txWrData    (txWrData),
    .pcwWrEn     (pcwWrEn),
    .pcwSlot     (pcwSlot),
    .pcwCtl      (pcwCtl),
    .pcwSig      (pcwSig),
    .masterCtl1  (masterCtl1),
    .masterCtl2  (masterCtl2),
    .extCtl      (extCtl),
    .dataRdEn    (dataRdEn),
    .dataRdSlot  (dataRdSlot),
    .statRdEn    (statRdEn),
    .statRdSlot  (statRdSlot),
    .dataOut     (dataOut),
    .statusOut   (statusOut)
  );
endmodule

// File: rtl/tdm_ds1_mapper_chk.sv
module tdm_ds1_mapper_chk
  import tdm_map_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              txWrEn,
  input logic [SLOT_W-1:0] txWrSlot,
  input logic              pcwWrEn,
  input logic [SLOT_W-1:0] pcwSlot,
  input logic [BYTE_W-1:0] masterCtl1,
  input logic              extCtl,
  input logic              dataRdEn,
  input logic              statRdEn
);
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(DS1_CH);

  p_tx_slot_r2: assert property (@(posedge clk) disable iff (!rstN)
    txWrEn |-> (txWrSlot != '0 && txWrSlot <= LAST_SLOT));

  p_tx_spacing_r2: assert property (@(posedge clk) disable iff (!rstN)
    txWrEn |=> !txWrEn);

  p_pcw_slot_r3: assert property (@(posedge clk) disable iff (!rstN)
    pcwWrEn |-> (pcwSlot != '0 && pcwSlot <= LAST_SLOT));

  p_master_no_pcw_r4: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(masterCtl1) |-> !pcwWrEn);

  p_ext_follow_r5: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(extCtl) |-> extCtl == $past(masterCtl1[EXT_CTL_BIT]));

  p_data_req_pulse_r7: assert property (@(posedge clk) disable iff (!rstN)
    dataRdEn |=> !dataRdEn);

  p_stat_req_pulse_r7: assert property (@(posedge clk) disable iff (!rstN)
    statRdEn |=> !statRdEn);

  p_req_apart_from_write_r7: assert property (@(posedge clk) disable iff (!rstN)
    dataRdEn |-> !txWrEn);
endmodule

bind tdm_ds1_mapper tdm_ds1_mapper_chk u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .txWrEn     (txWrEn),
  .txWrSlot   (txWrSlot),
  .pcwWrEn    (pcwWrEn),
  .pcwSlot    (pcwSlot),
  .masterCtl1 (masterCtl1),
  .extCtl     (extCtl),
  .dataRdEn   (dataRdEn),
  .statRdEn   (statRdEn)
);

// File: tb/sim_tdm_ds1_mapper.sv
`timescale 1ns/1ps
module sim_tdm_ds1_mapper;
  localparam int CLK_PERIOD = 488;
  localparam int SAMPLE_AT  = CLK_PERIOD * 3 / 4;
  localparam logic [7:0] PHASE_W = 8'h5A;
  localparam logic [7:0] MS1_W   = 8'hC3;
  localparam logic [7:0] MS2_W   = 8'h0F;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic framePulse = 1'b0, dataIn = 1'b0, ctl0In = 1'b0, ctl1In = 1'b0, extStatusIn = 1'b0;
  logic txWrEn, pcwWrEn, extCtl, dataRdEn, statRdEn, dataOut, statusOut;
  logic [4:0] txWrSlot, pcwSlot, dataRdSlot, statRdSlot;
  logic [7:0] txWrData, pcwCtl, pcwSig, masterCtl1, masterCtl2;
  logic [7:0] dataRdData = 8'h00, statRdData = 8'h00;
  logic [7:0] phaseStat = PHASE_W, masterStat1 = MS1_W, masterStat2 = MS2_W;

  always #(CLK_PERIOD/2) clk = ~clk;

  tdm_ds1_mapper u0 (
    .clk(clk), .rstN(rstN), .framePulse(framePulse), .dataIn(dataIn),
    .ctl0In(ctl0In), .ctl1In(ctl1In), .extStatusIn(extStatusIn),
    .txWrEn(txWrEn), .txWrSlot(txWrSlot), .txWrData(txWrData),
    .pcwWrEn(pcwWrEn), .pcwSlot(pcwSlot), .pcwCtl(pcwCtl), .pcwSig(pcwSig),
    .masterCtl1(masterCtl1), .masterCtl2(masterCtl2), .extCtl(extCtl),
    .dataRdEn(dataRdEn), .dataRdSlot(dataRdSlot), .dataRdData(dataRdData),
    .statRdEn(statRdEn), .statRdSlot(statRdSlot), .statRdData(statRdData),
    .phaseStat(phaseStat), .masterStat1(masterStat1), .masterStat2(masterStat2),
    .dataOut(dataOut), .statusOut(statusOut)
  );

  function automatic logic [7:0] dmem(input int s);
    return 8'((s * 37 + 5) % 256);
  endfunction

  function automatic logic [7:0] smem(input int s);
    return 8'((s * 11 + 129) % 256);
  endfunction

  // DS1-side buffer: one period of read latency
  always @(posedge clk) begin
    if (dataRdEn) dataRdData <= dmem(int'(dataRdSlot));
    if (statRdEn) statRdData <= smem(int'(statRdSlot));
  end

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // reference model state
  int q = 0;
  int frameNo = 0;
  int validFrames = 0;
  int jumpAt = -1;
  bit fpCur = 1'b0;
  bit fpEnable = 1'b1;
  bit justJumped = 1'b0;
  logic [7:0] drvD [32];
  logic [7:0] drvC0 [32];
  logic [7:0] drvC1 [32];
  int eTxEn = 0, eTxSlot = 0, eTxData = 0;
  int ePcwEn = 0, ePcwSlot = 0, ePcwCtl = 0, ePcwSig = 0;
  int eMc1 = 0, eMc2 = 0, eExt = 0, eLatch = 0;
  int eDRdEn = 0, eDRdSlot = 0, eSRdEn = 0, eSRdSlot = 0;

  function automatic logic [7:0] pick(input int fr);
    if (fr == 0) return 8'hFF;
    if (fr == 1) return 8'h00;
    return 8'($urandom_range(0, 255));
  endfunction

  task automatic drivePeriod();
    int ch, b;
    ch = q / 8;
    b = q % 8;
    if (b == 0) begin
      drvD[ch]  = pick(frameNo);
      drvC0[ch] = pick(frameNo);
      drvC1[ch] = pick(frameNo);
    end
    dataIn = drvD[ch][7-b];
    ctl0In = drvC0[ch][7-b];
    ctl1In = drvC1[ch][7-b];
    framePulse = fpCur;
    extStatusIn = ((frameNo % 2) == 1) ^ (q >= 128);
  endtask

  // expectations for the period following the one that ended at index q
  task automatic endOfPeriod();
    int ch, b, nch;
    ch = q / 8;
    b = q % 8;
    nch = (ch + 1) % 32;
    eTxEn = (b == 7 && ch % 4 != 0) ? 1 : 0;
    if (eTxEn == 1) begin
      eTxSlot = ch - ch / 4;
      eTxData = int'(drvD[ch]);
    end
    ePcwEn = (b == 7 && ch % 4 != 3) ? 1 : 0;
    if (ePcwEn == 1) begin
      ePcwSlot = ch - ch / 4 + 1;
      ePcwCtl = int'(drvC0[ch]);
      ePcwSig = int'(drvC1[ch]);
    end
    if (b == 7 && ch == 15) eMc1 = int'(drvC0[15]);
    if (b == 7 && ch == 31) eMc2 = int'(drvC0[31]);
    if (q == 255) begin
      eExt = (eMc1 >> 3) & 1;
      eLatch = int'(extStatusIn);
    end
    eDRdEn = (b == 5 && nch % 4 != 0) ? 1 : 0;
    if (eDRdEn == 1) eDRdSlot = nch - nch / 4;
    eSRdEn = (b == 5 && nch % 4 != 3) ? 1 : 0;
    if (eSRdEn == 1) eSRdSlot = nch - nch / 4 + 1;
  endtask

  function automatic int expDataByte(input int ch);
    if (ch % 4 == 0) return 255;
    return int'(dmem(ch - ch / 4));
  endfunction

  function automatic int expStatByte(input int ch);
    logic [7:0] v;
    if (ch == 3) return int'(PHASE_W);
    if (ch == 15) return int'(MS1_W);
    if (ch == 31) begin
      v = MS2_W;
      v[5] = eLatch[0];
      return int'(v);
    end
    if (ch % 4 != 3) return int'(smem(ch - ch / 4 + 1));
    return 255;
  endfunction

  task automatic compareAll();
    int ch, b;
    string serTag;
    ch = q / 8;
    b = q % 8;
    serTag = fpEnable ? "R6" : "R1";
    chk("R2", "txWrEn", int'(txWrEn), eTxEn);
    if (eTxEn == 1) begin
      chk("R2", "txWrSlot", int'(txWrSlot), eTxSlot);
      chk("R2", "txWrData", int'(txWrData), eTxData);
    end
    chk("R3", "pcwWrEn", int'(pcwWrEn), ePcwEn);
    if (ePcwEn == 1) begin
      chk("R3", "pcwSlot", int'(pcwSlot), ePcwSlot);
      chk("R3", "pcwCtl", int'(pcwCtl), ePcwCtl);
      chk("R3", "pcwSig", int'(pcwSig), ePcwSig);
    end
    if (justJumped) begin
      chk("R9", "no write for interrupted channel", int'(pcwWrEn), 0);
      justJumped = 1'b0;
    end
    chk("R4", "masterCtl1", int'(masterCtl1), eMc1);
    chk("R4", "masterCtl2", int'(masterCtl2), eMc2);
    chk("R5", "extCtl", int'(extCtl), eExt);
    chk("R7", "dataRdEn", int'(dataRdEn), eDRdEn);
    if (eDRdEn == 1) chk("R7", "dataRdSlot", int'(dataRdSlot), eDRdSlot);
    chk("R7", "statRdEn", int'(statRdEn), eSRdEn);
    if (eSRdEn == 1) chk("R7", "statRdSlot", int'(statRdSlot), eSRdSlot);
    if (q >= 8 || validFrames >= 1) begin
      chk(serTag, "dataOut", int'(dataOut), (expDataByte(ch) >> (7 - b)) & 1);
      chk("R8", "statusOut", int'(statusOut), (expStatByte(ch) >> (7 - b)) & 1);
    end
  endtask

  initial begin
    bit jumpNow;
    for (int i = 0; i < 32; i++) begin
      drvD[i] = 8'h00;
      drvC0[i] = 8'h00;
      drvC1[i] = 8'h00;
    end
    repeat (4) @(posedge clk);
    #(SAMPLE_AT);
    chk("R10", "txWrEn in reset", int'(txWrEn), 0);
    chk("R10", "pcwWrEn in reset", int'(pcwWrEn), 0);
    chk("R10", "masterCtl1 in reset", int'(masterCtl1), 0);
    chk("R10", "masterCtl2 in reset", int'(masterCtl2), 0);
    chk("R10", "extCtl in reset", int'(extCtl), 0);
    chk("R10", "dataRdEn in reset", int'(dataRdEn), 0);
    chk("R10", "statRdEn in reset", int'(statRdEn), 0);
    chk("R10", "dataOut in reset", int'(dataOut), 1);
    chk("R10", "statusOut in reset", int'(statusOut), 1);
    @(posedge clk);
    #1;
    rstN = 1'b1;
    q = 0;
    fpCur = 1'b1;
    drivePeriod();
    while (frameNo < 9) begin
      @(posedge clk);
      endOfPeriod();
      jumpNow = (q == jumpAt);
      if (q == 255) begin
        frameNo++;
        validFrames++;
        fpEnable = !(frameNo == 5 || frameNo == 6);
        jumpAt = (frameNo == 3) ? 102 : -1;
      end
      if (jumpNow) begin
        q = 0;
        validFrames = 0;
        justJumped = 1'b1;
        jumpAt = -1;
      end else begin
        q = (q + 1) % 256;
      end
      fpCur = (q == 0) && (fpEnable || jumpNow);
      #1;
      drivePeriod();
      #(SAMPLE_AT - 1);
      compareAll();
    end
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL R1 watchdog expired: actual 0 expected 1");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule